// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block sits between a small set of interrupt-raising peripherals and a processor that has a single interrupt request line and a single acknowledge line. Each peripheral raises its own request and receives its own acknowledge. The arbiter combines the requests into one processor interrupt. When the processor acknowledges, the arbiter picks exactly one channel, acknowledges that peripheral, and places an 8-bit entry number on the data bus. The processor uses that number to index a table of service routine addresses.

Software configures the arbiter through byte-wide register writes. The registers are a channel mask, one table entry number per channel, and a control byte. The control byte holds a global enable bit and a priority-order bit. Priority is fixed by default, so the lowest channel number wins. Setting the order bit selects rotating priority, in which the channel serviced most recently drops to the lowest rank.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Reset clears the mask, every entry-number register and the control byte. After reset `cpu_int` is 0 even with requests high, `irq_ack` is 0, `vec_oe` is 0 and `vec_data` is 0.
- R2: `cpu_int` is 1 exactly when control bit 0 (global enable) is 1 and at least one channel n has `irq_req[n]` and mask bit n both high. It responds combinationally in the same cycle.
- R3: Register address 0 is the mask, and mask bit n admits channel n (0x03 admits both channels). A channel whose mask bit is 0 is never acknowledged.
- R4: The clock edge that first samples `cpu_inta` high latches a winner, provided a pending channel exists. From that edge until `cpu_inta` falls, exactly one bit of `irq_ack` is high. No bit of `irq_ack` is ever high while `cpu_inta` is low.
- R5: With control bit 1 clear (fixed order), the lowest-numbered pending channel wins.
- R6: With control bit 1 set (rotating order), the pending channel that follows the most recently granted channel in circular order wins. After reset the most recent grant counts as the last channel, so channel 0 leads.
- R7: Register address 1+n holds the entry number of channel n. While a channel is acknowledged, `vec_oe` is 1 and `vec_data` carries that channel's entry number (for example 13 or 17). At all other times `vec_oe` is 0 and `vec_data` is 0.
- R8: The latched winner and its entry number stay unchanged while `cpu_inta` stays high, even if requests, the mask or the enable change.
- R9: If `cpu_inta` rises while no channel is pending, nothing is acknowledged and `vec_oe` stays 0 for that whole acknowledge.
- R10: Register address NCH+1 (3 for two channels) is the control byte: bit 0 is the global enable and bit 1 is the order select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (2) | Register address |
| cfg_wdata | input | 8 | Register write data |
| irq_req | input | NCH (2) | Per-channel interrupt requests |
| irq_ack | output | NCH (2) | Per-channel acknowledges |
| cpu_int | output | 1 | Interrupt to the processor |
| cpu_inta | input | 1 | Interrupt acknowledge from the processor |
| vec_data | output | 8 | Table entry number for the data bus |
| vec_oe | output | 1 | Data bus drive enable for `vec_data` |

## Verification
The bench sweeps every combination of enable, mask and request pattern and checks the interrupt line at each one; a design that ignored the enable or a mask bit would raise a stray interrupt there. Simultaneous requests are resolved in both orders. In fixed order, a design that favoured the high channel would return entry 17 where 13 is expected. In rotating order, a design that forgot to record grants would keep serving channel 0. The bench changes requests in the middle of an acknowledge, which catches a winner that is recomputed instead of held. It also acknowledges with nothing pending, which catches a design that drives a stale entry number onto the bus.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Priority order selected by control bit 1
    typedef enum logic {
        ORDER_FIXED  = 1'b0,
        ORDER_ROTATE = 1'b1
    } order_e;

    // Control byte: bit 0 global enable, bit 1 order select
    typedef struct packed {
        order_e order;
        logic   on;
    } ctl_t;

    // Register slot helpers
    function automatic int unsigned mask_slot();
        return 0;
    endfunction

    function automatic int unsigned entry_slot(int unsigned ch);
        return ch + 1;
    endfunction

    function automatic int unsigned ctl_slot(int unsigned nch);
        return nch + 1;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  byte_t                 wdata,
    output logic [NCH-1:0]        mask,
    output logic [NCH-1:0][7:0]   entry_tab,
    output ctl_t                  ctl
);

    localparam logic [AW-1:0] MASK_A = AW'(mask_slot());
    localparam logic [AW-1:0] CTL_A  = AW'(ctl_slot(NCH));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            ctl  <= '{order: ORDER_FIXED, on: 1'b0};
        end else if (we) begin
            if (addr == MASK_A) mask <= wdata[NCH-1:0];
            if (addr == CTL_A)  ctl  <= '{order: order_e'(wdata[1]), on: wdata[0]};
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_entry
        localparam logic [AW-1:0] ENT_A = AW'(entry_slot(g));
        always_ff @(posedge clk) begin
            if (rst)                        entry_tab[g] <= '0;
            else if (we && addr == ENT_A)   entry_tab[g] <= wdata;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] pend,
    input  order_e         order,
    input  logic [CW-1:0]  last,
    output logic [NCH-1:0] win_oh,
    output logic [CW-1:0]  win_idx
);

    int   cand;
    logic found;

    always_comb begin
        win_oh  = '0;
        win_idx = '0;
        found   = 1'b0;
        cand    = 0;
        for (int off = 0; off < NCH; off++) begin
            if (order == ORDER_ROTATE) cand = (int'(last) + 1 + off) % NCH;
            else                       cand = off;
            if (!found && pend[cand]) begin
                found        = 1'b1;
                win_oh[cand] = 1'b1;
                win_idx      = CW'(cand);
            end
        end
    end

endmodule

// File: rtl/irq_grant_ctl.sv
module irq_grant_ctl
    import irq_arb_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           inta,
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] win_oh,
    input  logic [CW-1:0]  win_idx,
    output logic [NCH-1:0] grant_oh,
    output logic [CW-1:0]  grant_idx,
    output logic [CW-1:0]  last
);

    logic inta_q;
    logic inta_rise;

    assign inta_rise = inta && !inta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_q    <= 1'b0;
            grant_oh  <= '0;
            grant_idx <= '0;
            last      <= CW'(NCH - 1);
        end else begin
            inta_q <= inta;
            if (inta_rise) begin
                if (|pend) begin
                    grant_oh  <= win_oh;
                    grant_idx <= win_idx;
                    last      <= win_idx;
                end else begin
                    grant_oh  <= '0;
                end
            end else if (!inta) begin
                grant_oh <= '0;
            end
        end
    end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [7:0]     cfg_wdata,
    input  logic [NCH-1:0] irq_req,
    output logic [NCH-1:0] irq_ack,
    output logic           cpu_int,
    input  logic           cpu_inta,
    output logic [7:0]     vec_data,
    output logic           vec_oe
);

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]        mask;
    logic [NCH-1:0][7:0]   entry_tab;
    ctl_t                  ctl;
    logic [NCH-1:0]        pend;
    logic [NCH-1:0]        win_oh;
    logic [CW-1:0]         win_idx;
    logic [NCH-1:0]        grant_oh;
    logic [CW-1:0]         grant_idx;
    logic [CW-1:0]         last;

    irq_cfg_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .mask      (mask),
        .entry_tab (entry_tab),
        .ctl       (ctl)
    );

    assign pend    = irq_req & mask & {NCH{ctl.on}};
    assign cpu_int = |pend;

    irq_prio_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .pend    (pend),
        .order   (ctl.order),
        .last    (last),
        .win_oh  (win_oh),
        .win_idx (win_idx)
    );

    irq_grant_ctl #(.NCH(NCH), .CW(CW)) u_grant (
        .clk       (clk),
        .rst       (rst),
        .inta      (cpu_inta),
        .pend      (pend),
        .win_oh    (win_oh),
        .win_idx   (win_idx),
        .grant_oh  (grant_oh),
        .grant_idx (grant_idx),
        .last      (last)
    );

    assign irq_ack  = grant_oh & {NCH{cpu_inta}};
    assign vec_oe   = |irq_ack;
    assign vec_data = vec_oe ? entry_tab[grant_idx] : 8'h00;

endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] irq_req,
    input logic [NCH-1:0] irq_ack,
    input logic           cpu_int,
    input logic           cpu_inta,
    input logic [7:0]     vec_data,
    input logic           vec_oe
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!cpu_int && irq_ack == '0 && !vec_oe));

    // R2
    int_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_int |-> (|irq_req));

    // R4
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    // R4
    ack_under_inta_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |-> cpu_inta);

    // R7
    bus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_oe |-> (vec_data == 8'h00));

    // R8
    winner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_inta && $past(cpu_inta) && (|$past(irq_ack)))
            |-> (irq_ack == $past(irq_ack) && vec_data == $past(vec_data)));

endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .cpu_int  (cpu_int),
    .cpu_inta (cpu_inta),
    .vec_data (vec_data),
    .vec_oe   (vec_oe)
);

// File: tb/test_irq_vec_arbiter.sv
module test_irq_vec_arbiter;

    localparam int NCH = 2;
    localparam int AW  = 2;
    localparam logic [7:0] E0 = 8'd13;
    localparam logic [7:0] E1 = 8'd17;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [AW-1:0]  cfg_addr = '0;
    logic [7:0]     cfg_wdata = '0;
    logic [NCH-1:0] irq_req = '0;
    logic [NCH-1:0] irq_ack;
    logic           cpu_int;
    logic           cpu_inta = 1'b0;
    logic [7:0]     vec_data;
    logic           vec_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_vec_arbiter #(.NCH(NCH), .AW(AW)) i_irq_vec_arbiter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_ack(irq_ack),
        .cpu_int(cpu_int), .cpu_inta(cpu_inta), .vec_data(vec_data),
        .vec_oe(vec_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One acknowledge: raise inta, check grant after the latching edge, drop inta
    task automatic service(input string tag, input logic [NCH-1:0] exp_ack, input logic [7:0] exp_data);
        @(negedge clk);
        cpu_inta = 1'b1;
        @(negedge clk);
        chk({tag, " ack"}, irq_ack, exp_ack);
        chk({tag, " oe"}, vec_oe, |exp_ack);
        chk({tag, " data"}, vec_data, exp_data);
        cpu_inta = 1'b0;
        #1;
        chk({tag, " ack released"}, irq_ack, '0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_last;
        logic [NCH-1:0] pat;
        logic [NCH-1:0] ea;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_req = 2'b11;
        #1;
        chk("R1 int", cpu_int, 1'b0);
        chk("R1 ack", irq_ack, '0);
        chk("R1 oe", vec_oe, 1'b0);
        chk("R1 data", vec_data, 8'h00);
        service("R1 disabled after reset", 2'b00, 8'h00);

        // R7: entry numbers at addresses 1 and 2
        wr(2'd1, E0);
        wr(2'd2, E1);

        // R2 R3 R10: sweep enable, mask, requests
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 4; m++) begin
                wr(2'd3, 8'(en));
                wr(2'd0, 8'(m));
                for (int r = 0; r < 4; r++) begin
                    @(negedge clk);
                    irq_req = NCH'(r);
                    #1;
                    chk($sformatf("R2 R3 int en=%0d m=%0d r=%0d", en, m, r),
                        cpu_int, (en == 1) && ((r & m) != 0));
                end
            end
        end

        // R5 R7: fixed order
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h03);
        for (int r = 1; r < 4; r++) begin
            irq_req = NCH'(r);
            ea = (r & 1) ? 2'b01 : 2'b10;
            service($sformatf("R5 fixed r=%0d", r), ea, (r & 1) ? E0 : E1);
        end

        // R9: acknowledge with nothing pending
        irq_req = 2'b00;
        service("R9 empty", 2'b00, 8'h00);

        // R3: masked channel never wins
        wr(2'd0, 8'h02);
        irq_req = 2'b11;
        service("R3 mask ch0", 2'b10, E1);
        wr(2'd0, 8'h03);

        // R8: winner held while requests and enable change
        @(negedge clk);
        irq_req = 2'b11;
        cpu_inta = 1'b1;
        @(negedge clk);
        chk("R8 initial ack", irq_ack, 2'b01);
        irq_req = 2'b10;
        @(negedge clk);
        chk("R8 held after req change", irq_ack, 2'b01);
        chk("R8 data held", vec_data, E0);
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R8 held after disable", irq_ack, 2'b01);
        chk("R8 data held after disable", vec_data, E0);
        cpu_inta = 1'b0;
        @(negedge clk);

        // R6: rotating order from a fresh reset
        do_reset();
        wr(2'd1, E0);
        wr(2'd2, E1);
        wr(2'd0, 8'h03);
        wr(2'd3, 8'h03);
        exp_last = NCH - 1;
        for (int k = 0; k < 12; k++) begin
            pat = (k < 4) ? 2'b11 : NCH'(1 + ((k * k + k / 2) % 3));
            irq_req = pat;
            if (pat[(exp_last + 1) % NCH]) exp_last = (exp_last + 1) % NCH;
            else                           exp_last = exp_last;
            ea = NCH'(1) << exp_last;
            service($sformatf("R6 rotate k=%0d pat=%0d", k, pat), ea, (exp_last == 0) ? E0 : E1);
        end

        // R6: return to fixed order (control bit 1 cleared)
        wr(2'd3, 8'h01);
        irq_req = 2'b11;
        service("R10 fixed again", 2'b01, E0);
        service("R10 fixed repeat", 2'b01, E0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule